// File: doc/BRIEF.md
# Vertical line-averaging compressor

This block shrinks a 4:2:2 luma/chroma active-video stream in the vertical direction for a picture-in-picture inset. Samples arrive one per valid cycle, interleaved as chroma-blue, luma, chroma-red, luma along each line. A line-start marker flags the first sample of every line, and a field-start marker flags the first sample of a field. The block folds each group of N consecutive lines into one output line. Every output sample is the rounded mean of the N samples found at the same horizontal position. Because the components interleave by position, luma and both chroma components are averaged separately with no extra logic. Running sums live in a single line buffer. Horizontal scaling is left to other logic.

The ratio N is taken from a 3-bit code at each field start. The code value is the ratio itself, and codes the block does not support fall back to a ratio of 1. An even ratio always mixes lines of opposite chroma phase, which cancels the line-to-line phase alternation of PAL. A registered status flag reports this case, so that the system can bypass its separate chroma delay line.

Top module: `vline_compress`

## Requirements
- R1: After reset, out_valid, out_sol, out_sof and pal_bypass are 0. No output is produced for input received before the first field start (in_valid with in_sof high).
- R2: The active ratio N is the ratio_code value when the code is 2, 3, 4 or 6. Codes 0, 1, 5 and 7 give N = 1.
- R3: With N = 1, every input sample at a position below MAX_W leaves unchanged on out_data. Each output sample carries out_sol for position 0 and appears two clock cycles after the edge that captured the input.
- R4: With N > 1, each output sample equals floor((2S + N) / (2N)), with the result clamped to 255. S is the sum of the samples at that horizontal position over the N lines of the group. Halves round up.
- R5: Lines are counted in groups of N from the field start, and one output line is emitted on the last line of each group. out_sol marks its position-0 sample. out_sof additionally marks position 0 of the first output line of the field.
- R6: pal_bypass is 1 when the active N is 2, 4 or 6, and 0 when it is 1 or 3. It takes its new value one cycle after the field-start sample is captured.
- R7: A change of ratio_code inside a field has no effect on the output or on pal_bypass until the next field start.
- R8: A group left incomplete when a new field starts is discarded. Its lines never contribute to any output sample.
- R9: Samples at horizontal positions MAX_W and above are ignored. They produce no output and do not change any sum.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ratio_code | input | 3 | Requested compression ratio, sampled at field start |
| in_valid | input | 1 | Input sample valid |
| in_sof | input | 1 | First sample of a field (also starts a line) |
| in_sol | input | 1 | First sample of a line |
| in_data | input | DATA_W | Multiplexed luma/chroma sample |
| out_valid | output | 1 | Output sample valid |
| out_sof | output | 1 | First sample of the first output line of a field |
| out_sol | output | 1 | First sample of an output line |
| out_data | output | DATA_W | Averaged sample |
| pal_bypass | output | 1 | External PAL delay line may be bypassed |

## Verification
An averaged sample leaves the block two cycles after the edge that captures the last line's sample at that position. pal_bypass is due one cycle after the field-start sample is captured. The scoreboard does not depend on the exact output cycle. The driver computes every expected sample, with its markers, at the moment it drives the input, and queues it. The monitor pops and compares at each falling edge where out_valid is high, so any extra, missing or reordered output is reported. The two-cycle output latency is checked by a clocked property, and the bypass flag is checked by the driver exactly one falling edge after each field-start sample.

// File: rtl/vlc_pkg.sv
package vlc_pkg;

  // Control flags carried with each sample through the pipeline.
  typedef struct packed {
    logic       valid;  // sample belongs to an active field and is in range
    logic       fresh;  // first line of a group: sum restarts from zero
    logic       emit;   // last line of a group: produce an output sample
    logic       sol;    // horizontal position 0
    logic       sof;    // position 0 of the first output line of a field
    logic [2:0] ratio;  // ratio in force for this sample
  } stage_ctl_t;

  // Map the register code to a supported ratio; others mean no compression.
  function automatic logic [2:0] decode_ratio(input logic [2:0] code);
    case (code)
      3'd2, 3'd3, 3'd4, 3'd6: decode_ratio = code;
      default:                decode_ratio = 3'd1;
    endcase
  endfunction

  function automatic logic ratio_is_even(input logic [2:0] r);
    ratio_is_even = (r == 3'd2) || (r == 3'd4) || (r == 3'd6);
  endfunction

endpackage

// File: rtl/vlc_ctrl.sv
module vlc_ctrl
  import vlc_pkg::*;
#(
  parameter int MAX_W = 1440,
  parameter int AW    = $clog2(MAX_W)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic             in_sof,
  input  logic             in_sol,
  input  logic [2:0]       ratio_code,
  output stage_ctl_t       cur_ctl,
  output logic [AW-1:0]    cur_addr,
  output logic [2:0]       ratio_act,
  output logic             pal_bypass
);

  localparam int XW = $clog2(MAX_W + 1);

  logic [XW-1:0] xnext;
  logic [2:0]    lcnt;
  logic          active;
  logic          first;

  logic          field_go;
  logic          line_go;
  logic          grp_end;
  logic [2:0]    n_eff;
  logic [2:0]    l_eff;
  logic [XW-1:0] x_eff;
  logic          first_eff;
  logic          in_range;

  always_comb begin
    field_go  = in_valid && in_sof;
    line_go   = in_valid && (in_sol || in_sof);
    grp_end   = (lcnt == ratio_act - 3'd1);
    n_eff     = field_go ? decode_ratio(ratio_code) : ratio_act;
    if (field_go)      l_eff = 3'd0;
    else if (line_go)  l_eff = grp_end ? 3'd0 : lcnt + 3'd1;
    else               l_eff = lcnt;
    x_eff     = line_go ? '0 : xnext;
    in_range  = (x_eff < XW'(MAX_W));
    if (field_go)                first_eff = 1'b1;
    else if (line_go && grp_end) first_eff = 1'b0;
    else                         first_eff = first;

    cur_ctl.valid = in_valid && (active || field_go) && in_range;
    cur_ctl.fresh = (l_eff == 3'd0);
    cur_ctl.emit  = (l_eff == n_eff - 3'd1);
    cur_ctl.sol   = (x_eff == '0);
    cur_ctl.sof   = (x_eff == '0) && first_eff;
    cur_ctl.ratio = n_eff;
    cur_addr      = x_eff[AW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      xnext      <= '0;
      lcnt       <= 3'd0;
      active     <= 1'b0;
      first      <= 1'b0;
      ratio_act  <= 3'd1;
      pal_bypass <= 1'b0;
    end else if (in_valid) begin
      xnext <= in_range ? x_eff + XW'(1) : x_eff;
      lcnt  <= l_eff;
      first <= first_eff;
      if (field_go) begin
        active     <= 1'b1;
        ratio_act  <= n_eff;
        pal_bypass <= ratio_is_even(n_eff);
      end
    end
  end

endmodule

// File: rtl/vlc_linebuf.sv
module vlc_linebuf #(
  parameter int DEPTH = 1440,
  parameter int WIDTH = 11,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);

  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/vlc_divider.sv
module vlc_divider #(
  parameter int DATA_W = 8,
  parameter int SUM_W  = DATA_W + 3,
  parameter int FRAC_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              in_sol,
  input  logic              in_sof,
  input  logic [2:0]        in_ratio,
  input  logic [SUM_W-1:0]  in_sum,
  output logic              out_valid,
  output logic              out_sol,
  output logic              out_sof,
  output logic [DATA_W-1:0] out_data
);

  localparam int PW = SUM_W + FRAC_W + 1;
  localparam logic [PW-1:0] RECIP3 = PW'(((1 << FRAC_W) + 2) / 3);
  localparam logic [PW-1:0] RECIP6 = PW'(((1 << FRAC_W) + 5) / 6);
  localparam logic [PW-1:0] HALF   = PW'(1 << (FRAC_W - 1));
  localparam logic [PW-1:0] MAXV   = PW'((1 << DATA_W) - 1);

  logic [PW-1:0] wide;
  logic [PW-1:0] quot;

  always_comb begin
    wide = PW'(in_sum);
    case (in_ratio)
      3'd2:    quot = (wide + PW'(1)) >> 1;
      3'd4:    quot = (wide + PW'(2)) >> 2;
      3'd3:    quot = (wide * RECIP3 + HALF) >> FRAC_W;
      3'd6:    quot = (wide * RECIP6 + HALF) >> FRAC_W;
      default: quot = wide;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_sol   <= 1'b0;
      out_sof   <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      out_sol   <= in_valid && in_sol;
      out_sof   <= in_valid && in_sof;
      if (in_valid) out_data <= (quot > MAXV) ? MAXV[DATA_W-1:0] : quot[DATA_W-1:0];
    end
  end

endmodule

// File: rtl/vline_compress.sv
module vline_compress
  import vlc_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int MAX_W  = 1440,
  parameter int FRAC_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        ratio_code,
  input  logic              in_valid,
  input  logic              in_sof,
  input  logic              in_sol,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  output logic              out_sof,
  output logic              out_sol,
  output logic [DATA_W-1:0] out_data,
  output logic              pal_bypass
);

  localparam int AW    = $clog2(MAX_W);
  localparam int SUM_W = DATA_W + 3;

  stage_ctl_t        cur_ctl;
  logic [AW-1:0]     cur_addr;
  logic [2:0]        ratio_act;

  stage_ctl_t        s1_ctl;
  logic [AW-1:0]     s1_addr;
  logic [DATA_W-1:0] s1_data;
  logic [SUM_W-1:0]  rd_data;
  logic              fwd_q;
  logic [SUM_W-1:0]  fwd_data;
  logic [SUM_W-1:0]  prev_sum;
  logic [SUM_W-1:0]  sum_c;
  logic              buf_we;

  logic              s2_valid;
  logic              s2_sol;
  logic              s2_sof;
  logic [2:0]        s2_ratio;
  logic [SUM_W-1:0]  s2_sum;

  vlc_ctrl #(.MAX_W(MAX_W), .AW(AW)) ctrl_i (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_sof     (in_sof),
    .in_sol     (in_sol),
    .ratio_code (ratio_code),
    .cur_ctl    (cur_ctl),
    .cur_addr   (cur_addr),
    .ratio_act  (ratio_act),
    .pal_bypass (pal_bypass)
  );

  vlc_linebuf #(.DEPTH(MAX_W), .WIDTH(SUM_W), .AW(AW)) buf_i (
    .clk   (clk),
    .we    (buf_we),
    .waddr (s1_addr),
    .wdata (sum_c),
    .raddr (cur_addr),
    .rdata (rd_data)
  );

  // Stage 1: sample captured while the buffer read is in flight.
  always_ff @(posedge clk) begin
    if (rst) begin
      s1_ctl   <= '0;
      s1_addr  <= '0;
      s1_data  <= '0;
      fwd_q    <= 1'b0;
      fwd_data <= '0;
    end else begin
      s1_ctl   <= cur_ctl;
      s1_addr  <= cur_addr;
      s1_data  <= in_data;
      // Same-address write in this cycle: the read returns stale data.
      fwd_q    <= buf_we && (s1_addr == cur_addr);
      fwd_data <= sum_c;
    end
  end

  always_comb begin
    prev_sum = fwd_q ? fwd_data : rd_data;
    sum_c    = (s1_ctl.fresh ? '0 : prev_sum) + SUM_W'(s1_data);
    buf_we   = s1_ctl.valid && !s1_ctl.emit;
  end

  // Stage 2: completed group sums headed for the divider.
  always_ff @(posedge clk) begin
    if (rst) begin
      s2_valid <= 1'b0;
      s2_sol   <= 1'b0;
      s2_sof   <= 1'b0;
      s2_ratio <= 3'd1;
      s2_sum   <= '0;
    end else begin
      s2_valid <= s1_ctl.valid && s1_ctl.emit;
      s2_sol   <= s1_ctl.sol;
      s2_sof   <= s1_ctl.sof;
      s2_ratio <= s1_ctl.ratio;
      s2_sum   <= sum_c;
    end
  end

  vlc_divider #(.DATA_W(DATA_W), .SUM_W(SUM_W), .FRAC_W(FRAC_W)) div_i (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (s2_valid),
    .in_sol    (s2_sol),
    .in_sof    (s2_sof),
    .in_ratio  (s2_ratio),
    .in_sum    (s2_sum),
    .out_valid (out_valid),
    .out_sol   (out_sol),
    .out_sof   (out_sof),
    .out_data  (out_data)
  );

endmodule

// File: rtl/vlc_checker.sv
module vlc_checker
  import vlc_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       in_valid,
  input logic       in_sof,
  input logic [2:0] ratio_code,
  input logic       out_valid,
  input logic       out_sol,
  input logic       out_sof,
  input logic       pal_bypass,
  input logic [2:0] ratio_act
);

  AST_SOF_ON_LINE_START: assert property (@(posedge clk) disable iff (rst)
    out_sof |-> (out_sol && out_valid));  // R5

  AST_OUTPUT_LATENCY: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid, 3));  // R3

  AST_BYPASS_HELD: assert property (@(posedge clk) disable iff (rst)
    !$past(in_valid && in_sof) |-> $stable(pal_bypass));  // R7

  AST_BYPASS_MATCHES_CODE: assert property (@(posedge clk) disable iff (rst)
    ($past(in_valid && in_sof) && !$past(rst))
      |-> (pal_bypass == ratio_is_even(decode_ratio($past(ratio_code)))));  // R6

  AST_RATIO_SUPPORTED: assert property (@(posedge clk) disable iff (rst)
    (ratio_act == 3'd1) || (ratio_act == 3'd2) || (ratio_act == 3'd3) ||
    (ratio_act == 3'd4) || (ratio_act == 3'd6));  // R2

endmodule

bind vline_compress vlc_checker chk_i (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .in_sof     (in_sof),
  .ratio_code (ratio_code),
  .out_valid  (out_valid),
  .out_sol    (out_sol),
  .out_sof    (out_sof),
  .pal_bypass (pal_bypass),
  .ratio_act  (ratio_act)
);

// File: tb/vline_compress_tb_top.sv
module vline_compress_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int DW         = 8;
  localparam int MW         = 16;
  localparam int WATCHDOG   = 150000;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [2:0]    ratio_code = 3'd1;
  logic          in_valid = 1'b0;
  logic          in_sof = 1'b0;
  logic          in_sol = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic          out_valid;
  logic          out_sof;
  logic          out_sol;
  logic [DW-1:0] out_data;
  logic          pal_bypass;

  int checks = 0;
  int failures = 0;

  // scoreboard
  int    q_data[$];
  bit    q_sol[$];
  bit    q_sof[$];
  string q_tag[$];
  string cur_tag = "R1";

  // reference model state
  int m_sum[MW];
  int m_n = 1;
  int m_l = 0;
  bit m_active = 0;
  bit m_first = 0;
  bit exp_byp = 0;
  bit byp_pend = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vline_compress #(.DATA_W(DW), .MAX_W(MW)) dut_i (
    .clk        (clk),
    .rst        (rst),
    .ratio_code (ratio_code),
    .in_valid   (in_valid),
    .in_sof     (in_sof),
    .in_sol     (in_sol),
    .in_data    (in_data),
    .out_valid  (out_valid),
    .out_sof    (out_sof),
    .out_sol    (out_sol),
    .out_data   (out_data),
    .pal_bypass (pal_bypass)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int ratio_of(input int code);
    return (code == 2 || code == 3 || code == 4 || code == 6) ? code : 1;
  endfunction

  function automatic int avg(input int s, input int n);
    int q;
    q = (2 * s + n) / (2 * n);
    return (q > 255) ? 255 : q;
  endfunction

  // monitor: compare each produced sample against the queue head
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (q_data.size() == 0) begin
        check(0, "R5", "unexpected output sample", out_data, -1);
      end else begin
        int    d;
        bit    sl;
        bit    sf;
        string t;
        d  = q_data.pop_front();
        sl = q_sol.pop_front();
        sf = q_sof.pop_front();
        t  = q_tag.pop_front();
        check(out_data == DW'(d), t, "out_data", out_data, d);
        check(out_sol == sl, t, "out_sol", out_sol, sl);
        check(out_sof == sf, t, "out_sof", out_sof, sf);
      end
    end
  end

  task automatic step();
    @(negedge clk);
    if (byp_pend) begin
      check(pal_bypass == exp_byp, "R6", "pal_bypass after field start", pal_bypass, exp_byp);
      byp_pend = 0;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      step();
      in_valid = 0; in_sof = 0; in_sol = 0;
    end
  endtask

  // kind 0: ramp from seed, kind 1: constant seed
  task automatic send_line(input int len, input bit sof, input int kind, input int seed);
    if (sof) begin
      m_n = ratio_of(int'(ratio_code));
      m_l = 0;
      m_active = 1;
      m_first = 1;
      exp_byp = (m_n % 2) == 0;
    end else if (m_active) begin
      if (m_l == m_n - 1) begin
        m_l = 0;
        m_first = 0;
      end else m_l = m_l + 1;
    end
    for (int x = 0; x < len; x++) begin
      int d;
      d = (kind == 0) ? ((seed + x * 13) & 255) : (seed & 255);
      step();
      in_valid = 1;
      in_sol   = (x == 0);
      in_sof   = sof && (x == 0);
      in_data  = DW'(d);
      if (sof && x == 0) byp_pend = 1;
      if (m_active && x < MW) begin
        int s;
        s = ((m_l == 0) ? 0 : m_sum[x]) + d;
        if (m_l == m_n - 1) begin
          q_data.push_back(avg(s, m_n));
          q_sol.push_back(x == 0);
          q_sof.push_back(x == 0 && m_first);
          q_tag.push_back(cur_tag);
        end else m_sum[x] = s;
      end
    end
  endtask

  task automatic send_field(input int code, input int lines, input int len,
                            input int kind, input int seed);
    ratio_code = 3'(code);
    for (int l = 0; l < lines; l++)
      send_line(len, l == 0, kind, seed + l * 29);
  endtask

  initial begin
    #(WATCHDOG * CLK_PERIOD);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    step();
    // R1: reset state
    check(out_valid == 0, "R1", "out_valid after reset", out_valid, 0);
    check(out_sol == 0 && out_sof == 0, "R1", "markers after reset", out_sol | out_sof, 0);
    check(pal_bypass == 0, "R1", "pal_bypass after reset", pal_bypass, 0);
    // R1: lines before any field start produce nothing
    ratio_code = 3'd1;
    send_line(8, 0, 0, 7);
    send_line(8, 0, 0, 9);
    idle(6);

    cur_tag = "R3";                  // pass-through, ratio 1
    send_field(1, 3, 8, 0, 11);
    idle(3);

    cur_tag = "R4";                  // ratio 2
    send_field(2, 4, 10, 0, 40);
    idle(2);
    send_field(3, 6, 12, 0, 90);     // ratio 3
    idle(2);
    send_field(4, 8, 9, 0, 5);       // ratio 4
    idle(2);
    // ratio 6 with rounding tie: three lines 255, three lines 0 -> 128
    ratio_code = 3'd6;
    for (int l = 0; l < 6; l++) send_line(6, l == 0, 1, (l < 3) ? 255 : 0);
    for (int l = 0; l < 6; l++) send_line(6, 0, 1, 255);   // maximum sums
    idle(2);
    // ratio 2 tie 255+0 -> 128
    ratio_code = 3'd2;
    send_line(4, 1, 1, 255);
    send_line(4, 0, 1, 0);
    idle(2);

    cur_tag = "R2";                  // unsupported codes act as ratio 1
    send_field(0, 2, 6, 0, 3);
    send_field(5, 2, 6, 0, 70);
    send_field(7, 2, 6, 0, 140);
    idle(3);

    cur_tag = "R7";                  // mid-field code change deferred
    ratio_code = 3'd2;
    send_line(8, 1, 0, 17);
    ratio_code = 3'd3;
    idle(2);
    check(pal_bypass == 1, "R7", "pal_bypass after mid-field code change", pal_bypass, 1);
    send_line(8, 0, 0, 33);
    send_line(8, 0, 0, 51);
    send_line(8, 0, 0, 77);
    idle(2);
    check(pal_bypass == 1, "R7", "pal_bypass held within field", pal_bypass, 1);
    send_field(3, 3, 8, 0, 120);     // now takes effect
    idle(2);

    cur_tag = "R8";                  // partial group discarded
    send_field(3, 4, 8, 1, 250);
    send_field(3, 3, 8, 0, 10);
    idle(2);
    send_field(2, 1, 8, 1, 200);
    send_field(2, 2, 8, 1, 20);
    idle(2);

    cur_tag = "R9";                  // positions beyond MAX_W ignored
    send_field(2, 4, MW + 5, 0, 60);
    idle(2);

    cur_tag = "R5";                  // one-sample lines back to back
    send_field(2, 6, 1, 0, 100);
    send_field(1, 3, 2, 0, 200);
    idle(8);
    check(q_data.size() == 0, "R5", "expected samples not produced", q_data.size(), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule